// File: doc/BRIEF.md
# NAND Strobe Timing Calculator

This block converts three requested flash strobe timings into whole controller clock cycles. The three timings are the command/address setup time, the write-pulse active width and the hold time, each given in nanoseconds. The controller clock frequency is given in kHz. A single-cycle `start` captures every input. The block then works out all three cycle counts, checks each count against its limit, and produces the configuration field codes. It also converts each count back into nanoseconds so that software or a log can report the timing actually achieved.

All six divisions run one after another on one shared bit-serial divider. The results appear together on the cycle that `done` pulses, and they hold until the next completed run. A start that arrives while a run is in progress is ignored. A clock frequency of zero is rejected straight away and never reaches the divider.

Top module: `nand_strobe_timer`

## Requirements
- R1: Each count equals the truncated quotient of (requested ns × clk_khz) / 1,000,000, plus one, with a floor of 1. A request of 0 ns therefore gives a count of 1.
- R2: The setup limit is 4 when `ext_mode`=0 and 8 when `ext_mode`=1. The active and hold limits are always 8. A count above its limit sets its error bit and reads as count 0 and code 0. No saturation is applied. `err` bit 0 is setup, bit 1 is active and bit 2 is hold. `fail` is the OR of the error bits.
- R3: With `use_defaults`=1 the requested values are ignored. Each count is set to its limit and no error bit is set.
- R4: Each field code equals its count minus one. The code is 0 when the error bit for that parameter is set.
- R5: Each report output equals the truncated quotient of (count × 1,000,000) / clk_khz. A rejected count reports 0.
- R6: For a nonzero clock, `done` is high for exactly one cycle, 229 rising edges after the edge that samples `start`. The general figure is 6×(NS_W+KHZ_W+2)+1.
- R7: When `clk_khz`=0, all three error bits and `fail` are set, all counts, codes and reports read 0, and `done` pulses on the first edge after the start edge.
- R8: `busy` is high from the start edge until `done` rises. A `start` seen while `busy` is high has no effect on that run's results or timing.
- R9: After reset every output reads 0. Outputs change only on the edge that raises `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Captures the inputs and launches a calculation |
| use_defaults | input | 1 | Ignore the requested times and use the limits |
| ext_mode | input | 1 | Selects the wider setup limit (8 instead of 4) |
| clk_khz | input | KHZ_W | Controller clock frequency in kHz |
| setup_ns | input | NS_W | Requested setup time |
| active_ns | input | NS_W | Requested write-pulse active width |
| hold_ns | input | NS_W | Requested hold time |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion strobe |
| fail | output | 1 | At least one timing could not be met |
| err | output | 3 | Per-parameter error: bit 0 setup, bit 1 active, bit 2 hold |
| setup_cyc | output | CYC_W | Setup count |
| active_cyc | output | CYC_W | Active-width count |
| hold_cyc | output | CYC_W | Hold count |
| setup_code | output | CODE_W | Setup field code |
| active_code | output | CODE_W | Active field code |
| hold_code | output | CODE_W | Hold field code |
| setup_rpt | output | RPT_W | Achieved setup time in ns |
| active_rpt | output | RPT_W | Achieved active width in ns |
| hold_rpt | output | RPT_W | Achieved hold time in ns |

## Verification
A run on a nonzero clock lands all of its results on one edge, 229 edges after the start edge. A zero clock lands them on the first edge after the start edge. The driver notes the cycle count at the falling edge where it raises `start`, so the monitor expects a difference of 230, or 2 for a zero clock, at the falling edge where it sees `done`. Every output is read at that falling edge, and also a few cycles later to confirm that the values still hold.

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer #(
  parameter int NS_W           = 16,
  parameter int KHZ_W          = 20,
  parameter int SCALE          = 1000000,
  parameter int SETUP_LIM_BASE = 4,
  parameter int SETUP_LIM_EXT  = 8,
  parameter int PULSE_LIM      = 8,
  localparam int LIM_MAX = (SETUP_LIM_EXT > PULSE_LIM) ? SETUP_LIM_EXT : PULSE_LIM,
  localparam int CYC_W   = $clog2(LIM_MAX + 1),
  localparam int CODE_W  = $clog2(LIM_MAX),
  localparam int RPT_W   = $clog2(LIM_MAX * SCALE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              use_defaults,
  input  logic              ext_mode,
  input  logic [KHZ_W-1:0]  clk_khz,
  input  logic [NS_W-1:0]   setup_ns,
  input  logic [NS_W-1:0]   active_ns,
  input  logic [NS_W-1:0]   hold_ns,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [2:0]        err,
  output logic [CYC_W-1:0]  setup_cyc,
  output logic [CYC_W-1:0]  active_cyc,
  output logic [CYC_W-1:0]  hold_cyc,
  output logic [CODE_W-1:0] setup_code,
  output logic [CODE_W-1:0] active_code,
  output logic [CODE_W-1:0] hold_code,
  output logic [RPT_W-1:0]  setup_rpt,
  output logic [RPT_W-1:0]  active_rpt,
  output logic [RPT_W-1:0]  hold_rpt
);
  localparam int PW = NS_W + KHZ_W;
  localparam int BW = $clog2(PW + 1);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN, S_FIN} st_t;

  st_t              st;
  logic [2:0]       op;
  logic [BW-1:0]    bits;
  logic [PW-1:0]    quo;
  logic [KHZ_W-1:0] rem;
  logic [NS_W-1:0]  req_q [3];
  logic [KHZ_W-1:0] khz_q;
  logic             dflt_q, ext_q;
  logic [CYC_W-1:0] w_cyc [3];
  logic [RPT_W-1:0] w_rpt [3];
  logic [2:0]       w_err;

  assign busy = (st != S_IDLE);

  wire [KHZ_W-1:0] divisor = (op < 3'd3) ? KHZ_W'(SCALE) : khz_q;
  wire [KHZ_W:0]   rem_sh  = {rem, quo[PW-1]};
  wire             take    = rem_sh >= {1'b0, divisor};

  logic [PW-1:0] dividend;
  always_comb begin
    case (op)
      3'd0:    dividend = PW'(req_q[0]) * PW'(khz_q);
      3'd1:    dividend = PW'(req_q[1]) * PW'(khz_q);
      3'd2:    dividend = PW'(req_q[2]) * PW'(khz_q);
      3'd3:    dividend = PW'(w_cyc[0]) * PW'(SCALE);
      3'd4:    dividend = PW'(w_cyc[1]) * PW'(SCALE);
      default: dividend = PW'(w_cyc[2]) * PW'(SCALE);
    endcase
  end

  wire [PW:0]      raw_cnt = {1'b0, quo} + 1'b1;
  wire [PW:0]      cnt1    = (raw_cnt == '0) ? (PW+1)'(1) : raw_cnt;
  wire [CYC_W-1:0] lim     = (op == 3'd0) ? (ext_q ? CYC_W'(SETUP_LIM_EXT) : CYC_W'(SETUP_LIM_BASE))
                                          : CYC_W'(PULSE_LIM);
  wire             over    = cnt1 > (PW+1)'(lim);

  function automatic logic [CODE_W-1:0] to_code(input logic [CYC_W-1:0] c);
    return (c == '0) ? '0 : CODE_W'(c - 1'b1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= '0; bits <= '0; quo <= '0; rem <= '0;
      khz_q <= '0; dflt_q <= 1'b0; ext_q <= 1'b0; w_err <= '0;
      done <= 1'b0; fail <= 1'b0; err <= '0;
      setup_cyc <= '0; active_cyc <= '0; hold_cyc <= '0;
      setup_code <= '0; active_code <= '0; hold_code <= '0;
      setup_rpt <= '0; active_rpt <= '0; hold_rpt <= '0;
      for (int i = 0; i < 3; i++) begin
        req_q[i] <= '0; w_cyc[i] <= '0; w_rpt[i] <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          req_q[0] <= setup_ns; req_q[1] <= active_ns; req_q[2] <= hold_ns;
          khz_q <= clk_khz; dflt_q <= use_defaults; ext_q <= ext_mode;
          op <= '0;
          if (clk_khz == '0) begin
            w_err <= 3'b111;
            for (int i = 0; i < 3; i++) begin
              w_cyc[i] <= '0; w_rpt[i] <= '0;
            end
            st <= S_FIN;
          end else begin
            st <= S_LOAD;
          end
        end
        S_LOAD: begin
          quo <= dividend; rem <= '0; bits <= BW'(PW); st <= S_RUN;
        end
        S_RUN: if (bits != '0) begin
          quo  <= {quo[PW-2:0], take};
          rem  <= take ? KHZ_W'(rem_sh - {1'b0, divisor}) : rem_sh[KHZ_W-1:0];
          bits <= bits - 1'b1;
        end else begin
          for (int i = 0; i < 3; i++) begin
            if (op == 3'(i)) begin
              if (dflt_q) begin
                w_cyc[i] <= lim; w_err[i] <= 1'b0;
              end else if (over) begin
                w_cyc[i] <= '0; w_err[i] <= 1'b1;
              end else begin
                w_cyc[i] <= CYC_W'(cnt1); w_err[i] <= 1'b0;
              end
            end
            if (op == 3'(i + 3)) w_rpt[i] <= RPT_W'(quo);
          end
          if (op == 3'd5) st <= S_FIN;
          else begin
            op <= op + 1'b1; st <= S_LOAD;
          end
        end
        S_FIN: begin
          done <= 1'b1; fail <= |w_err; err <= w_err;
          setup_cyc <= w_cyc[0]; active_cyc <= w_cyc[1]; hold_cyc <= w_cyc[2];
          setup_code <= to_code(w_cyc[0]); active_code <= to_code(w_cyc[1]);
          hold_code <= to_code(w_cyc[2]);
          setup_rpt <= w_rpt[0]; active_rpt <= w_rpt[1]; hold_rpt <= w_rpt[2];
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({err, setup_cyc, active_cyc, hold_cyc, setup_rpt, active_rpt, hold_rpt})); // R9
  AST_CODE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err[0]) |-> (CYC_W'(setup_code) + 1'b1 == setup_cyc)); // R4
  AST_ERR_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err[1]) |-> (active_cyc == '0 && active_code == '0)); // R2
  AST_SETUP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (setup_cyc <= (ext_q ? CYC_W'(SETUP_LIM_EXT) : CYC_W'(SETUP_LIM_BASE)))); // R2
  AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done); // R8
endmodule

// File: tb/test_nand_strobe_timer.sv
`timescale 1ns/1ps
module test_nand_strobe_timer;
  localparam int PW  = 36;
  localparam int LAT = 6 * (PW + 2) + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, use_defaults = 1'b0, ext_mode = 1'b0;
  logic [19:0] clk_khz = '0;
  logic [15:0] setup_ns = '0, active_ns = '0, hold_ns = '0;
  logic busy, done, fail;
  logic [2:0] err;
  logic [3:0] setup_cyc, active_cyc, hold_cyc;
  logic [2:0] setup_code, active_code, hold_code;
  logic [22:0] setup_rpt, active_rpt, hold_rpt;

  nand_strobe_timer i_nand_strobe_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .use_defaults(use_defaults), .ext_mode(ext_mode),
    .clk_khz(clk_khz), .setup_ns(setup_ns), .active_ns(active_ns), .hold_ns(hold_ns),
    .busy(busy), .done(done), .fail(fail), .err(err),
    .setup_cyc(setup_cyc), .active_cyc(active_cyc), .hold_cyc(hold_cyc),
    .setup_code(setup_code), .active_code(active_code), .hold_code(hold_code),
    .setup_rpt(setup_rpt), .active_rpt(active_rpt), .hold_rpt(hold_rpt));

  typedef struct {
    longint cnt [3];
    longint code [3];
    longint rpt [3];
    longint err;
    longint lat;
    longint t0;
  } exp_t;

  exp_t   sb[$];
  exp_t   last;
  int     n_chk = 0, n_fail = 0;
  longint cyc = 0;
  bit     finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string req, string what, longint act, longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(longint s, longint a, longint h, longint khz, bit dflt, bit ext);
    exp_t e;
    longint req [3];
    longint lim [3];
    req[0] = s; req[1] = a; req[2] = h;
    lim[0] = ext ? 8 : 4; lim[1] = 8; lim[2] = 8;
    e.err = 0;
    for (int i = 0; i < 3; i++) begin
      if (khz == 0) begin
        e.cnt[i] = 0; e.err |= (1 << i);
      end else if (dflt) begin
        e.cnt[i] = lim[i];
      end else begin
        e.cnt[i] = req[i] * khz / 1000000 + 1;
        if (e.cnt[i] < 1) e.cnt[i] = 1;
        if (e.cnt[i] > lim[i]) begin
          e.cnt[i] = 0; e.err |= (1 << i);
        end
      end
      e.code[i] = (e.cnt[i] == 0) ? 0 : e.cnt[i] - 1;
      e.rpt[i]  = (khz == 0) ? 0 : e.cnt[i] * 1000000 / khz;
    end
    e.lat = (khz == 0) ? 1 : LAT;
    return e;
  endfunction

  task automatic compare(string tag, exp_t e);
    check("R1/R2", {tag, " setup_cyc"}, setup_cyc, e.cnt[0]);
    check("R1/R2", {tag, " active_cyc"}, active_cyc, e.cnt[1]);
    check("R1/R2", {tag, " hold_cyc"}, hold_cyc, e.cnt[2]);
    check("R4", {tag, " setup_code"}, setup_code, e.code[0]);
    check("R4", {tag, " active_code"}, active_code, e.code[1]);
    check("R4", {tag, " hold_code"}, hold_code, e.code[2]);
    check("R5", {tag, " setup_rpt"}, setup_rpt, e.rpt[0]);
    check("R5", {tag, " active_rpt"}, active_rpt, e.rpt[1]);
    check("R5", {tag, " hold_rpt"}, hold_rpt, e.rpt[2]);
    check("R2", {tag, " err"}, err, e.err);
    check("R2", {tag, " fail"}, fail, e.err != 0);
  endtask

  // monitor: pops expected items as done pulses
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (sb.size() == 0) check("R8", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check("R6", "done latency", cyc - e.t0, e.lat + 1);
          compare("result", e);
          last = e;
        end
      end
    end
  end

  task automatic launch(longint s, longint a, longint h, longint khz, bit dflt, bit ext);
    exp_t e;
    @(negedge clk);
    e = model(s, a, h, khz, dflt, ext);
    e.t0 = cyc;
    sb.push_back(e);
    setup_ns = 16'(s); active_ns = 16'(a); hold_ns = 16'(h);
    clk_khz = 20'(khz); use_defaults = dflt; ext_mode = ext;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_run();
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    setup_ns = 16'd999; clk_khz = 20'd12345; use_defaults = 1'b1;
    repeat (3) @(negedge clk);
    compare("held", last); // R9
    check("R8", "busy after done", busy, 0);
  endtask

  task automatic run(longint s, longint a, longint h, longint khz, bit dflt, bit ext);
    launch(s, a, h, khz, dflt, ext);
    finish_run();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "reset done", done, 0);
    check("R9", "reset busy", busy, 0);
    check("R9", "reset setup_cyc", setup_cyc, 0);
    check("R9", "reset hold_rpt", hold_rpt, 0);
    check("R9", "reset err", err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(10, 25, 15, 100000, 0, 0);   // R1 basic
    run(30, 70, 0, 100000, 0, 0);    // R1 zero request, R2 boundaries
    run(40, 100, 80, 100000, 0, 0);  // R2 all over limit
    run(60, 20, 20, 100000, 0, 0);   // R2 base setup rejected
    run(60, 20, 20, 100000, 0, 1);   // R2 extended setup accepted
    run(15, 15, 15, 66666, 0, 0);    // R1 truncation
    run(500, 500, 500, 133000, 1, 0);// R3 defaults base
    run(0, 0, 0, 133000, 1, 1);      // R3 defaults extended
    run(10, 10, 10, 0, 0, 0);        // R7 zero clock
    run(5, 5, 5, 0, 1, 1);           // R7 zero clock wins over defaults
    run(65535, 65535, 65535, 1, 0, 0);// R1 tiny clock
    run(7, 3, 1, 1000000, 0, 1);     // R5 report at 1 GHz

    // R8: a second start while busy is ignored
    launch(20, 30, 40, 100000, 0, 0);
    repeat (20) @(negedge clk);
    check("R8", "busy mid-run", busy, 1);
    setup_ns = 16'd900; clk_khz = 20'd0; use_defaults = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_run();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule